// File: doc/BRIEF.md
# E1 Timeslot-Zero Si/E-Bit Transmit Selector

This block decides the value of the first bit of timeslot 0 in every outgoing E1 frame. A frame counter elsewhere in the transmit path raises a one-cycle slot strobe when that bit position comes up. It also supplies the frame number within the 16-frame CRC-4 multiframe. On that strobe the block picks the bit from a configured source and registers it. The result is held on `si_bit` until the next frame. `si_sel` tells the serializer whether this bit is the one to drive onto the line.

Without CRC-4, three sources are available. Two programmable bits can be used: one for frames that carry the alignment word and one for frames that do not. The Si bit supplied by the system side can be passed through. The system timeslot-0 bit can also be forwarded transparently, taken from system frames of one chosen parity. With CRC-4 enabled, the block owns only frames 13 and 15, where the bit becomes the E bit. Either the two programmable bits fill those frames, or automatic E-bit generation reports far-end CRC errors and multiframe-alignment loss from the local receiver.

Top module: `e1_si_tx_select`

## Requirements
- R1: After reset `si_bit` is 1, `si_sel` is 0, and the errored-submultiframe queue is empty, so the first automatic E bit is 1.
- R2: `si_bit` and `si_sel` change only on the clock edge that samples `slot_stb` high; error strobes, timer pulses and input changes in other cycles leave them unchanged.
- R3: Without CRC-4 and with `src_sel` = 2'b00, an even frame number (alignment-word frame, `frame_num[0]` = 0) sends `reg_sif` and an odd one sends `reg_sinf`, with `si_sel` = 1.
- R4: Without CRC-4 and with `src_sel` = 2'b01, the bit sent is `sys_si` as sampled on the strobe, with `si_sel` = 1.
- R5: Without CRC-4 and with `src_sel[1]` = 1, the bit sent is `sys_ts0` from the most recent strobed frame whose `frame_num[0]` equals `tp_odd`, including the current frame; before any such frame the held value is 1.
- R6: With CRC-4 on, every frame except 13 and 15 gives `si_sel` = 0 and `si_bit` = 1, whatever `src_sel` is.
- R7: With CRC-4 on and `auto_ebit` = 0, frame 13 sends `reg_sif` and frame 15 sends `reg_sinf`, with `si_sel` = 1.
- R8: With CRC-4 and `auto_ebit` on, and no error queued and no alignment condition, frames 13 and 15 send 1.
- R9: Each `err_smf` pulse forces exactly one later E bit to 0, in the same cycle if it coincides with an E-bit slot. The queue holds at most 2^QW-1 entries and saturates there.
- R10: With automatic E bits on, `rx_lmfa` = 1 and `iw_tmr_en` = 0, both E bits are 0 and the queue is not consumed.
- R11: With `iw_tmr_en` = 1 during `rx_lmfa`, E bits follow the queue until `iw_tmr_exp` is seen. From then on they stay 0 until `rx_lmfa` falls, even if `iw_tmr_exp` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_stb | input | 1 | One-cycle strobe at timeslot-0 bit-1 of each frame |
| frame_num | input | FNW | Frame number within the multiframe |
| crc4_en | input | 1 | CRC-4 multiframe mode |
| src_sel | input | 2 | Non-CRC-4 source: 00 registers, 01 system Si, 1x transparent |
| reg_sif | input | 1 | Programmed bit for alignment-word frames / frame 13 |
| reg_sinf | input | 1 | Programmed bit for non-alignment frames / frame 15 |
| sys_si | input | 1 | System-side Si bit for the current frame |
| sys_ts0 | input | 1 | System timeslot-0 bit for transparent forwarding |
| tp_odd | input | 1 | Transparent capture parity: 1 odd frames, 0 even |
| auto_ebit | input | 1 | Automatic E-bit generation enable |
| err_smf | input | 1 | Pulse per errored received CRC-4 submultiframe |
| rx_lmfa | input | 1 | Receiver in loss of CRC-4 multiframe alignment |
| iw_tmr_en | input | 1 | Interworking timer enable |
| iw_tmr_exp | input | 1 | Interworking timer expired |
| si_bit | output | 1 | Registered bit for timeslot-0 bit 1 |
| si_sel | output | 1 | 1 when `si_bit` should be driven to the line |

## Verification
An error strobe can arrive in the same cycle as an E-bit slot. The incoming error must then be used at once when the queue is empty, and the count must stay unchanged when the queue is already non-empty. The bench provokes both cases. It judges them by counting the zeros and ones on the following E slots against its own queue count. The interworking-timer expiry pulse can also come in the cycle right before an E slot while the receiver is out of multiframe alignment. The bench checks that the sticky zero starts at that slot and is released only after `rx_lmfa` falls.

// File: rtl/e1si_pkg.sv
package e1si_pkg;

  typedef enum logic [1:0] {
    SRC_REG  = 2'b00,
    SRC_SYS  = 2'b01,
    SRC_TPA  = 2'b10,
    SRC_TPB  = 2'b11
  } si_src_e;

  // Alignment-word frames are the even frames of the multiframe.
  function automatic logic frame_has_fas(input logic lsb);
    return ~lsb;
  endfunction

  // Queue step: add an incoming error, take one away on consume, clip to max.
  function automatic int queue_step(input int cnt, input logic inc,
                                    input logic take, input int maxv);
    int n;
    n = cnt + int'(inc) - int'(take);
    if (n > maxv) n = maxv;
    return n;
  endfunction

endpackage

// File: rtl/e1si_tp_hold.sv
module e1si_tp_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic slot_stb,
  input  logic frame_lsb,
  input  logic tp_odd,
  input  logic sys_ts0,
  output logic tp_val
);
  logic hold_q;
  logic par_match;

  assign par_match = (frame_lsb == tp_odd);
  assign tp_val    = par_match ? sys_ts0 : hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                      hold_q <= 1'b1;
    else if (slot_stb && par_match)  hold_q <= sys_ts0;
  end

  // R5
  tp_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_stb && par_match) |=> (hold_q == $past(sys_ts0)));

endmodule

// File: rtl/e1si_ebit.sv
module e1si_ebit #(
  parameter int QW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic e_slot,
  input  logic err_smf,
  input  logic rx_lmfa,
  input  logic tmr_en,
  input  logic tmr_exp,
  output logic ebit_val
);
  import e1si_pkg::*;

  localparam int QMAX = (1 << QW) - 1;

  logic [QW-1:0] q_cnt;
  logic          tmr_lat;
  logic          tmr_now;
  logic          force_zero;
  logic          pending;
  logic          consume;
  int            q_next;

  assign tmr_now    = tmr_lat | (tmr_en & tmr_exp);
  assign force_zero = rx_lmfa & (~tmr_en | tmr_now);
  assign pending    = (q_cnt != '0) | err_smf;
  assign consume    = e_slot & ~force_zero & pending;
  assign ebit_val   = ~(force_zero | pending);

  always_comb q_next = queue_step(int'(q_cnt), err_smf, consume, QMAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_cnt   <= '0;
      tmr_lat <= 1'b0;
    end else begin
      q_cnt   <= QW'(q_next);
      tmr_lat <= rx_lmfa & tmr_now;
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_cnt == QW'(QMAX) && !consume) |=> (q_cnt == QW'(QMAX)));

  // R9
  one_per_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !err_smf) |=> (q_cnt == $past(q_cnt) - 1'b1));

  // R11
  tmr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_lmfa |=> !tmr_lat);

endmodule

// File: rtl/e1_si_tx_select.sv
module e1_si_tx_select #(
  parameter int MF_LEN = 16,
  parameter int QW     = 3,
  localparam int FNW   = $clog2(MF_LEN)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           slot_stb,
  input  logic [FNW-1:0] frame_num,
  input  logic           crc4_en,
  input  logic [1:0]     src_sel,
  input  logic           reg_sif,
  input  logic           reg_sinf,
  input  logic           sys_si,
  input  logic           sys_ts0,
  input  logic           tp_odd,
  input  logic           auto_ebit,
  input  logic           err_smf,
  input  logic           rx_lmfa,
  input  logic           iw_tmr_en,
  input  logic           iw_tmr_exp,
  output logic           si_bit,
  output logic           si_sel
);
  import e1si_pkg::*;

  localparam logic [FNW-1:0] E_FR_A = FNW'(MF_LEN - 3);
  localparam logic [FNW-1:0] E_FR_B = FNW'(MF_LEN - 1);

  logic is_e_a, is_e_b, is_e_frame, fas_frame;
  logic e_slot, tp_val, ebit_val;
  logic nxt_bit, nxt_sel;
  si_src_e src;

  assign is_e_a     = (frame_num == E_FR_A);
  assign is_e_b     = (frame_num == E_FR_B);
  assign is_e_frame = is_e_a | is_e_b;
  assign fas_frame  = frame_has_fas(frame_num[0]);
  assign e_slot     = slot_stb & crc4_en & auto_ebit & is_e_frame;
  assign src        = si_src_e'(src_sel);

  e1si_tp_hold u_tp (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_stb  (slot_stb & ~crc4_en),
    .frame_lsb (frame_num[0]),
    .tp_odd    (tp_odd),
    .sys_ts0   (sys_ts0),
    .tp_val    (tp_val)
  );

  e1si_ebit #(.QW(QW)) u_ebit (
    .clk      (clk),
    .rst_n    (rst_n),
    .e_slot   (e_slot),
    .err_smf  (err_smf),
    .rx_lmfa  (rx_lmfa),
    .tmr_en   (iw_tmr_en),
    .tmr_exp  (iw_tmr_exp),
    .ebit_val (ebit_val)
  );

  always_comb begin
    nxt_sel = 1'b1;
    nxt_bit = 1'b1;
    if (crc4_en) begin
      if (!is_e_frame)    nxt_sel = 1'b0;
      else if (auto_ebit) nxt_bit = ebit_val;
      else                nxt_bit = is_e_a ? reg_sif : reg_sinf;
    end else begin
      case (src)
        SRC_REG: nxt_bit = fas_frame ? reg_sif : reg_sinf;
        SRC_SYS: nxt_bit = sys_si;
        default: nxt_bit = tp_val;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      si_bit <= 1'b1;
      si_sel <= 1'b0;
    end else if (slot_stb) begin
      si_bit <= nxt_bit;
      si_sel <= nxt_sel;
    end
  end

  // R2
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_stb |=> ($stable(si_bit) && $stable(si_sel)));

  // R6
  crc_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_stb && crc4_en && !is_e_frame) |=> (!si_sel && si_bit));

  // R10
  lmfa_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (e_slot && rx_lmfa && !iw_tmr_en) |=> !si_bit);

  // R3
  reg_fas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_stb && !crc4_en && src_sel == 2'b00 && !frame_num[0])
      |=> (si_bit == $past(reg_sif) && si_sel));

endmodule

// File: tb/test_e1_si_tx_select.sv
module test_e1_si_tx_select;
  localparam int QMAX = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic slot_stb = 0, crc4_en = 0, reg_sif = 0, reg_sinf = 0, sys_si = 0;
  logic sys_ts0 = 0, tp_odd = 0, auto_ebit = 0, err_smf = 0, rx_lmfa = 0;
  logic iw_tmr_en = 0, iw_tmr_exp = 0;
  logic [3:0] frame_num = '0;
  logic [1:0] src_sel = 2'b00;
  logic si_bit, si_sel;

  int checks = 0, fails = 0;
  int m_q = 0;
  bit m_tl = 0, m_hold = 1;
  bit exp_bit, exp_sel;

  e1_si_tx_select #(.MF_LEN(16), .QW(3)) i_e1_si_tx_select (
    .clk(clk), .rst_n(rst_n), .slot_stb(slot_stb), .frame_num(frame_num),
    .crc4_en(crc4_en), .src_sel(src_sel), .reg_sif(reg_sif), .reg_sinf(reg_sinf),
    .sys_si(sys_si), .sys_ts0(sys_ts0), .tp_odd(tp_odd), .auto_ebit(auto_ebit),
    .err_smf(err_smf), .rx_lmfa(rx_lmfa), .iw_tmr_en(iw_tmr_en),
    .iw_tmr_exp(iw_tmr_exp), .si_bit(si_bit), .si_sel(si_sel));

  always #4 clk = ~clk;

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic check(input string req, input bit act_b, input bit act_s,
                       input bit eb, input bit es);
    checks++;
    if (act_b !== eb || act_s !== es) begin
      fails++;
      $display("FAIL %s: bit/sel actual %b/%b expected %b/%b", req, act_b, act_s, eb, es);
    end
  endtask

  // One clock cycle; model advances with the same inputs the design samples.
  task automatic step(input bit is_slot, input int fn, input bit e, input bit x,
                      input string req);
    bit tl_now, f0, eslot, match;
    int eff;
    @(negedge clk);
    slot_stb = is_slot; frame_num = 4'(fn); err_smf = e; iw_tmr_exp = x;
    tl_now = m_tl | (iw_tmr_en & x);
    f0 = rx_lmfa & (!iw_tmr_en | tl_now);
    eff = m_q + int'(e);
    eslot = is_slot && crc4_en && auto_ebit && (fn == 13 || fn == 15);
    if (is_slot) begin
      exp_sel = 1; exp_bit = 1;
      if (crc4_en) begin
        if (fn != 13 && fn != 15) exp_sel = 0;
        else if (auto_ebit) exp_bit = !(f0 || eff > 0);
        else exp_bit = (fn == 13) ? reg_sif : reg_sinf;
      end else if (src_sel == 2'b00) exp_bit = (fn % 2 == 0) ? reg_sif : reg_sinf;
      else if (src_sel == 2'b01) exp_bit = sys_si;
      else begin
        match = ((fn % 2) == int'(tp_odd));
        exp_bit = match ? sys_ts0 : m_hold;
        if (match) m_hold = sys_ts0;
      end
    end
    if (eslot && !f0 && eff > 0) eff--;
    m_q = (eff > QMAX) ? QMAX : eff;
    m_tl = rx_lmfa & tl_now;
    @(negedge clk);
    slot_stb = 0; err_smf = 0; iw_tmr_exp = 0;
    check(req, si_bit, si_sel, exp_bit, exp_sel);
  endtask

  initial begin
    exp_bit = 1; exp_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset", si_bit, si_sel, 1'b1, 1'b0);

    // R1: empty queue gives 1 on first E slot
    crc4_en = 1; auto_ebit = 1;
    step(1, 13, 0, 0, "R1 empty queue");
    crc4_en = 0; auto_ebit = 0;

    // R3/R4/R5 sweep: all frames, all register/system values
    for (int v = 0; v < 4; v++) begin
      reg_sif = v[0]; reg_sinf = v[1]; src_sel = 2'b00;
      for (int f = 0; f < 16; f++) step(1, f, 0, 0, "R3 register source");
      src_sel = 2'b01;
      for (int f = 0; f < 16; f++) begin
        sys_si = f[0] ^ f[1] ^ v[0];
        step(1, f, 0, 0, "R4 system Si");
      end
    end
    for (int p = 0; p < 2; p++) begin
      tp_odd = p[0]; src_sel = (p == 0) ? 2'b10 : 2'b11;
      for (int f = 0; f < 16; f++) begin
        sys_ts0 = f[1] ^ f[2];
        step(1, f, 0, 0, "R5 transparent");
      end
    end

    // R2: non-slot activity leaves output alone
    step(0, 3, 1, 1, "R2 no strobe");
    m_q = 0;
    rst_n = 0; @(negedge clk); rst_n = 1; m_tl = 0; m_hold = 1;
    exp_bit = 1; exp_sel = 0;

    // R6/R7: CRC-4 sweep with programmed bits
    crc4_en = 1;
    for (int v = 0; v < 4; v++) begin
      reg_sif = v[0]; reg_sinf = v[1]; src_sel = 2'(v);
      for (int f = 0; f < 16; f++)
        step(1, f, 0, 0, (f == 13 || f == 15) ? "R7 programmed E" : "R6 other frames");
    end

    // R8: automatic, idle
    auto_ebit = 1;
    step(1, 13, 0, 0, "R8 idle E");
    step(1, 15, 0, 0, "R8 idle E");

    // R9: queued errors, coincident error with empty and non-empty queue
    step(0, 2, 1, 0, "R2 err between slots");
    step(0, 2, 1, 0, "R2 err between slots");
    step(1, 13, 0, 0, "R9 queued error");
    step(1, 15, 1, 0, "R9 coincident nonempty");
    step(1, 13, 0, 0, "R9 queued error");
    step(1, 15, 0, 0, "R9 drained");
    step(1, 13, 1, 0, "R9 coincident empty");
    step(1, 15, 0, 0, "R9 after coincident");
    for (int i = 0; i < 10; i++) step(0, 4, 1, 0, "R2 err burst");
    for (int i = 0; i < 9; i++) step(1, (i % 2) ? 15 : 13, 0, 0, "R9 saturation");

    // R10: alignment loss, queue kept
    step(0, 4, 1, 0, "R2 err before lmfa");
    rx_lmfa = 1;
    step(1, 13, 0, 0, "R10 lmfa zero");
    step(1, 15, 0, 0, "R10 lmfa zero");
    rx_lmfa = 0;
    step(1, 13, 0, 0, "R10 queue kept");
    step(1, 15, 0, 0, "R10 after queue");

    // R11: interworking timer
    iw_tmr_en = 1; rx_lmfa = 1;
    step(1, 13, 0, 0, "R11 before expiry");
    step(0, 14, 0, 1, "R2 timer pulse");
    step(1, 15, 0, 0, "R11 expired");
    step(1, 13, 0, 0, "R11 sticky");
    rx_lmfa = 0;
    step(0, 14, 0, 0, "R2 lmfa drop");
    step(1, 15, 0, 0, "R11 released");
    rx_lmfa = 1;
    step(1, 13, 0, 1, "R11 expiry on slot");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule